// File: doc/BRIEF.md
# Execute Stage with Branch Resolution

This block is the combinational execute stage of a single-cycle 32-bit RISC-V integer core. It receives the current instruction word, the program counter, both register-file read values and the immediate already produced by decode. It also receives two operand-source selects from decode. An internal ALU-control decoder turns the opcode, funct3 and instruction bit 30 into one of ten ALU operations. Two operand multiplexers feed the ALU, and the ALU result goes on towards memory and write-back.

In parallel, a branch unit resolves control flow. It compares the two register values for conditional branches, and it forms the redirect address for taken branches and for both jump forms. It drives a jump flag and a jump target that go straight back to the fetch stage.

All outputs are pure functions of the inputs. The block holds no state, so it needs no clock and no reset.

Top module: `exec_stage`

## Requirements
- R1: For opcode 0110011 the ALU operation comes from funct3 and instruction bit 30: 000 gives ADD, or SUB when bit 30 is 1; 001 gives SLL; 010 gives SLT; 011 gives SLTU; 100 gives XOR; 101 gives SRL, or SRA when bit 30 is 1; 110 gives OR; 111 gives AND.
- R2: ALU operand A is `rs1_data` when `op1_sel` is 0 and `pc` when `op1_sel` is 1.
- R3: ALU operand B is `rs2_data` when `op2_sel` is 0 and `imm` when `op2_sel` is 1.
- R4: ADD returns the sum of the two selected operands, modulo 2^32.
- R5: For opcode 0010011 funct3 picks the operation as in R1. The exceptions are that funct3 000 is always ADD, whatever bit 30 holds, and that funct3 101 is SRA only when bit 30 is 1.
- R6: The shift operations use only bits 4:0 of operand B, and SRA fills with the sign bit of operand A.
- R7: SLT (signed) and SLTU (unsigned) return 1 when A < B and 0 otherwise.
- R8: Every opcode other than 0110011 and 0010011 makes the ALU perform ADD.
- R9: For opcode 1100011 with funct3 000 (equal), `jump_taken` is 1 exactly when `rs1_data` equals `rs2_data`.
- R10: For opcode 1100011, funct3 001 takes the branch when the values differ, 100 when less (signed), 101 when greater or equal (signed), 110 when less (unsigned) and 111 when greater or equal (unsigned). Codes 010 and 011 are never taken.
- R11: A taken conditional branch drives `jump_target` = `pc` + `imm`.
- R12: Opcode 1101111 always sets `jump_taken`, with `jump_target` = `pc` + `imm`.
- R13: Opcode 1100111 always sets `jump_taken`, with `jump_target` = (`rs1_data` + `imm`) with bit 0 forced to 0.
- R14: When no jump is taken (any opcode other than the three control-flow opcodes, or a branch whose condition fails), `jump_taken` is 0 and `jump_target` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| pc | input | XLEN | Address of that instruction |
| rs1_data | input | XLEN | First register-file read value |
| rs2_data | input | XLEN | Second register-file read value |
| imm | input | XLEN | Sign-extended immediate from decode |
| op1_sel | input | 1 | Operand A source: 0 register, 1 PC |
| op2_sel | input | 1 | Operand B source: 0 register, 1 immediate |
| alu_result | output | XLEN | ALU output |
| jump_taken | output | 1 | Redirect fetch this cycle |
| jump_target | output | XLEN | Redirect address, 0 when not jumping |

## Verification
There is no register between any input and any output, so the ALU result, the jump flag and the jump target are all due in the same cycle as the stimulus that produces them. The driver applies each vector just after a rising edge and queues its expected results. The monitor pops one item at the following falling edge, half a period later, once the combinational paths have settled. The vector is never changed between those two points, so each comparison sees exactly the vector whose expectation it holds.

// File: rtl/exec_pkg.sv
// exec_pkg: opcode constants and the ALU operation type shared by the
// execute-stage modules. Assumes the base 32-bit integer encoding.
package exec_pkg;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    localparam logic [2:0] CMP_EQ  = 3'b000;
    localparam logic [2:0] CMP_NE  = 3'b001;
    localparam logic [2:0] CMP_LT  = 3'b100;
    localparam logic [2:0] CMP_GE  = 3'b101;
    localparam logic [2:0] CMP_LTU = 3'b110;
    localparam logic [2:0] CMP_GEU = 3'b111;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLL,
        ALU_SLT,
        ALU_SLTU,
        ALU_XOR,
        ALU_SRL,
        ALU_SRA,
        ALU_OR,
        ALU_AND
    } alu_op_e;

endpackage

// File: rtl/exec_alu_ctrl.sv
// exec_alu_ctrl: turns opcode, funct3 and instruction bit 30 into an ALU
// operation. Assumes decode has already formed the operands; every
// opcode that is not register or immediate arithmetic gets ADD.
module exec_alu_ctrl
    import exec_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       alt_bit,
    output alu_op_e    alu_op
);

    // Select the ALU operation for the current instruction.
    always_comb begin
        alu_op = ALU_ADD;
        if (opcode == OPC_REG || opcode == OPC_IMM) begin
            unique case (funct3)
                3'b000:  alu_op = (opcode == OPC_REG && alt_bit) ? ALU_SUB : ALU_ADD;
                3'b001:  alu_op = ALU_SLL;
                3'b010:  alu_op = ALU_SLT;
                3'b011:  alu_op = ALU_SLTU;
                3'b100:  alu_op = ALU_XOR;
                3'b101:  alu_op = alt_bit ? ALU_SRA : ALU_SRL;
                3'b110:  alu_op = ALU_OR;
                default: alu_op = ALU_AND;
            endcase
        end
    end

endmodule

// File: rtl/exec_operand_mux.sv
// exec_operand_mux: two-way operand selector in front of the ALU.
// Assumes a single-bit select: 0 picks the register value, 1 the other source.
module exec_operand_mux #(
    parameter int WIDTH = 32
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] reg_val,
    input  logic [WIDTH-1:0] alt_val,
    output logic [WIDTH-1:0] operand
);

    // Pass the selected source to the ALU input.
    always_comb operand = sel ? alt_val : reg_val;

endmodule

// File: rtl/exec_alu.sv
// exec_alu: integer ALU with ten operations. Assumes XLEN is a power of
// two; the shift amount is the low log2(XLEN) bits of operand B.
module exec_alu
    import exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         alu_op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    logic           lt_signed;
    logic           lt_unsigned;

    // Shared shift amount and comparison results.
    always_comb begin
        shamt       = opb[SHW-1:0];
        lt_signed   = $signed(opa) < $signed(opb);
        lt_unsigned = opa < opb;
    end

    // Compute the result for the requested operation.
    always_comb begin
        unique case (alu_op)
            ALU_ADD:  result = opa + opb;
            ALU_SUB:  result = opa - opb;
            ALU_SLL:  result = opa << shamt;
            ALU_SLT:  result = {{(XLEN-1){1'b0}}, lt_signed};
            ALU_SLTU: result = {{(XLEN-1){1'b0}}, lt_unsigned};
            ALU_XOR:  result = opa ^ opb;
            ALU_SRL:  result = opa >> shamt;
            ALU_SRA:  result = $unsigned($signed(opa) >>> shamt);
            ALU_OR:   result = opa | opb;
            ALU_AND:  result = opa & opb;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/exec_branch_unit.sv
// exec_branch_unit: resolves conditional branches and both jump forms and
// produces the fetch redirect. Assumes imm is already sign-extended for
// the instruction's format. The target is zero whenever no jump is taken.
module exec_branch_unit
    import exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [6:0]      opcode,
    input  logic [2:0]      funct3,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] imm,
    output logic            taken,
    output logic [XLEN-1:0] target
);

    logic            cond;
    logic [XLEN-1:0] pc_rel;
    logic [XLEN-1:0] reg_rel;

    // Evaluate the branch condition that funct3 selects.
    always_comb begin
        unique case (funct3)
            CMP_EQ:  cond = rs1_val == rs2_val;
            CMP_NE:  cond = rs1_val != rs2_val;
            CMP_LT:  cond = $signed(rs1_val) < $signed(rs2_val);
            CMP_GE:  cond = $signed(rs1_val) >= $signed(rs2_val);
            CMP_LTU: cond = rs1_val < rs2_val;
            CMP_GEU: cond = rs1_val >= rs2_val;
            default: cond = 1'b0;
        endcase
    end

    // Candidate addresses: PC-relative and register-relative.
    always_comb begin
        pc_rel  = pc + imm;
        reg_rel = rs1_val + imm;
    end

    // Choose the redirect according to the opcode.
    always_comb begin
        taken  = 1'b0;
        target = '0;
        unique case (opcode)
            OPC_BRANCH: begin
                taken  = cond;
                target = cond ? pc_rel : '0;
            end
            OPC_JAL: begin
                taken  = 1'b1;
                target = pc_rel;
            end
            OPC_JALR: begin
                taken  = 1'b1;
                target = {reg_rel[XLEN-1:1], 1'b0};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exec_stage.sv
// exec_stage: combinational execute stage. Decodes the ALU operation,
// selects both ALU operands, computes the ALU result and resolves control
// flow for fetch. Assumes decode supplies the sign-extended immediate and
// the operand selects; there is no state, so there is no clock or reset.
module exec_stage
    import exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1_data,
    input  logic [XLEN-1:0] rs2_data,
    input  logic [XLEN-1:0] imm,
    input  logic            op1_sel,
    input  logic            op2_sel,
    output logic [XLEN-1:0] alu_result,
    output logic            jump_taken,
    output logic [XLEN-1:0] jump_target
);

    logic [6:0]      opcode;
    logic [2:0]      funct3;
    logic            alt_bit;
    alu_op_e         alu_op;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic            unused_instr;

    // Split out the instruction fields this stage decodes.
    always_comb begin
        opcode       = instr[6:0];
        funct3       = instr[14:12];
        alt_bit      = instr[30];
        unused_instr = ^{instr[31], instr[29:15], instr[11:7]};
    end

    exec_alu_ctrl u_alu_ctrl (
        .opcode  (opcode),
        .funct3  (funct3),
        .alt_bit (alt_bit),
        .alu_op  (alu_op)
    );

    exec_operand_mux #(.WIDTH(XLEN)) u_mux_a (
        .sel     (op1_sel),
        .reg_val (rs1_data),
        .alt_val (pc),
        .operand (opa)
    );

    exec_operand_mux #(.WIDTH(XLEN)) u_mux_b (
        .sel     (op2_sel),
        .reg_val (rs2_data),
        .alt_val (imm),
        .operand (opb)
    );

    exec_alu #(.XLEN(XLEN)) u_alu (
        .alu_op (alu_op),
        .opa    (opa),
        .opb    (opb),
        .result (alu_result)
    );

    exec_branch_unit #(.XLEN(XLEN)) u_branch (
        .opcode  (opcode),
        .funct3  (funct3),
        .pc      (pc),
        .rs1_val (rs1_data),
        .rs2_val (rs2_data),
        .imm     (imm),
        .taken   (jump_taken),
        .target  (jump_target)
    );

endmodule

// File: rtl/exec_stage_checker.sv
// exec_stage_checker: port-level assertions on the execute stage. The
// stage is combinational, so the checks are immediate assertions that are
// evaluated whenever the ports change.
module exec_stage_checker #(
    parameter int XLEN = 32
) (
    input logic [31:0]     instr,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] rs1_data,
    input logic [XLEN-1:0] rs2_data,
    input logic [XLEN-1:0] imm,
    input logic            op1_sel,
    input logic            op2_sel,
    input logic [XLEN-1:0] alu_result,
    input logic            jump_taken,
    input logic [XLEN-1:0] jump_target
);

    logic [XLEN-1:0] sel_a;
    logic [XLEN-1:0] sel_b;
    logic            is_ctrl;
    logic            is_cmp;

    // Observe the port contract of the stage.
    always_comb begin
        sel_a   = op1_sel ? pc : rs1_data;
        sel_b   = op2_sel ? imm : rs2_data;
        is_ctrl = instr[6:0] == 7'b1100011 || instr[6:0] == 7'b1101111 ||
                  instr[6:0] == 7'b1100111;
        is_cmp  = (instr[6:0] == 7'b0110011 || instr[6:0] == 7'b0010011) &&
                  (instr[14:12] == 3'b010 || instr[14:12] == 3'b011);

        if (instr[6:0] == 7'b0110011 && instr[14:12] == 3'b000 && !instr[30])
            AST_ADD_SUM: assert (alu_result == sel_a + sel_b)
                else $error("add mismatch"); // R4
        if (instr[6:0] == 7'b1100011 && instr[14:12] == 3'b000)
            AST_BEQ_FLAG: assert (jump_taken == (rs1_data == rs2_data))
                else $error("beq flag mismatch"); // R9
        if (instr[6:0] == 7'b1100111)
            AST_JALR_ALIGN: assert (jump_taken && !jump_target[0])
                else $error("jalr target not aligned"); // R13
        if (!is_ctrl)
            AST_NO_JUMP_IDLE: assert (!jump_taken && jump_target == '0)
                else $error("jump outside control flow"); // R14
        if (is_cmp)
            AST_CMP_BOOL: assert (alu_result[XLEN-1:1] == '0)
                else $error("compare not boolean"); // R7
        if (instr[6:0] == 7'b1101111)
            AST_JAL_TARGET: assert (jump_taken && jump_target == pc + imm)
                else $error("jal target mismatch"); // R12
    end

endmodule

bind exec_stage exec_stage_checker #(.XLEN(XLEN)) u_exec_stage_checker (
    .instr       (instr),
    .pc          (pc),
    .rs1_data    (rs1_data),
    .rs2_data    (rs2_data),
    .imm         (imm),
    .op1_sel     (op1_sel),
    .op2_sel     (op2_sel),
    .alu_result  (alu_result),
    .jump_taken  (jump_taken),
    .jump_target (jump_target)
);

// File: tb/exec_stage_bench.sv
// exec_stage_bench: scoreboard bench. The driver applies a vector after a
// rising edge and queues its expected results; the monitor pops and
// compares at the next falling edge.
module exec_stage_bench;

    localparam int XLEN = 32;

    typedef struct {
        logic [XLEN-1:0] res;
        logic            jmp;
        logic [XLEN-1:0] tgt;
        string           tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] pc = '0;
    logic [XLEN-1:0] rs1_data = '0;
    logic [XLEN-1:0] rs2_data = '0;
    logic [XLEN-1:0] imm = '0;
    logic            op1_sel = 1'b0;
    logic            op2_sel = 1'b0;
    logic [XLEN-1:0] alu_result;
    logic            jump_taken;
    logic [XLEN-1:0] jump_target;

    item_t queue_exp[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    exec_stage #(.XLEN(XLEN)) u_exec_stage (
        .instr       (instr),
        .pc          (pc),
        .rs1_data    (rs1_data),
        .rs2_data    (rs2_data),
        .imm         (imm),
        .op1_sel     (op1_sel),
        .op2_sel     (op2_sel),
        .alu_result  (alu_result),
        .jump_taken  (jump_taken),
        .jump_target (jump_target)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                       input logic [6:0] opc);
        return {f7, 5'd0, 5'd0, f3, 5'd0, opc};
    endfunction

    task automatic drive(input logic [31:0] i, input logic [XLEN-1:0] p,
                         input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input logic [XLEN-1:0] im, input logic s1, input logic s2,
                         input logic [XLEN-1:0] e_res, input logic e_jmp,
                         input logic [XLEN-1:0] e_tgt, input string tag);
        item_t it;
        @(posedge clk);
        #0.5;
        instr = i; pc = p; rs1_data = a; rs2_data = b; imm = im;
        op1_sel = s1; op2_sel = s2;
        it.res = e_res; it.jmp = e_jmp; it.tgt = e_tgt; it.tag = tag;
        queue_exp.push_back(it);
    endtask

    // Monitor: compare the settled outputs against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && queue_exp.size() > 0) begin
            item_t it;
            it = queue_exp.pop_front();
            n_vec++;
            if (alu_result !== it.res || jump_taken !== it.jmp || jump_target !== it.tgt) begin
                n_bad++;
                $display("FAIL %s: got res=%h jmp=%b tgt=%h, expected res=%h jmp=%b tgt=%h",
                         it.tag, alu_result, jump_taken, jump_target, it.res, it.jmp, it.tgt);
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R14 reset state: all inputs zero
        drive(32'h0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 32'h0, "R14 idle zero");
        // R1 R4 register add and wrap
        drive(mk(7'h00, 3'd0, 7'h33), 0, 5, 7, 0, 0, 0, 32'd12, 0, 0, "R1 R4 add");
        drive(mk(7'h00, 3'd0, 7'h33), 0, 32'hFFFF_FFFF, 2, 0, 0, 0, 32'd1, 0, 0, "R4 add wrap");
        drive(mk(7'h20, 3'd0, 7'h33), 0, 5, 7, 0, 0, 0, 32'hFFFF_FFFE, 0, 0, "R1 sub");
        // R2 operand A from pc
        drive(mk(7'h00, 3'd0, 7'h33), 32'h1000, 32'h55, 4, 0, 1, 0, 32'h1004, 0, 0, "R2 pc operand");
        // R3 operand B from imm
        drive(mk(7'h00, 3'd0, 7'h13), 0, 10, 99, 32'hFFFF_FFFD, 0, 1, 32'd7, 0, 0, "R3 imm operand");
        // R5 immediate add ignores bit 30
        drive(mk(7'h20, 3'd0, 7'h13), 0, 10, 0, 32'h400, 0, 1, 32'h40A, 0, 0, "R5 addi bit30");
        drive(mk(7'h20, 3'd5, 7'h13), 0, 32'h8000_0000, 0, 32'h404, 0, 1, 32'hF800_0000, 0, 0, "R5 R6 srai");
        drive(mk(7'h00, 3'd5, 7'h33), 0, 32'h8000_0000, 32'h24, 0, 0, 0, 32'h0800_0000, 0, 0, "R6 srl");
        drive(mk(7'h00, 3'd1, 7'h33), 0, 1, 32'h21, 0, 0, 0, 32'd2, 0, 0, "R6 sll");
        // R7 signed and unsigned compare
        drive(mk(7'h00, 3'd2, 7'h33), 0, 32'hFFFF_FFFF, 1, 0, 0, 0, 32'd1, 0, 0, "R7 slt");
        drive(mk(7'h00, 3'd3, 7'h33), 0, 32'hFFFF_FFFF, 1, 0, 0, 0, 32'd0, 0, 0, "R7 sltu");
        drive(mk(7'h00, 3'd4, 7'h33), 0, 32'hF0F0, 32'hFF00, 0, 0, 0, 32'h0FF0, 0, 0, "R1 xor");
        drive(mk(7'h00, 3'd6, 7'h33), 0, 32'hF0F0, 32'hFF00, 0, 0, 0, 32'hFFF0, 0, 0, "R1 or");
        drive(mk(7'h00, 3'd7, 7'h33), 0, 32'hF0F0, 32'hFF00, 0, 0, 0, 32'hF000, 0, 0, "R1 and");
        // R8 load opcode with bit 30 set still adds; R14 no jump
        drive(mk(7'h20, 3'd2, 7'h03), 0, 32'h100, 0, 8, 0, 1, 32'h108, 0, 0, "R8 R14 load add");
        // R9 R11 beq
        drive(mk(7'h00, 3'd0, 7'h63), 32'h2000, 9, 9, 32'h10, 0, 0, 32'h12, 1, 32'h2010, "R9 R11 beq taken");
        drive(mk(7'h00, 3'd0, 7'h63), 32'h2000, 9, 8, 32'h10, 0, 0, 32'h11, 0, 0, "R9 R14 beq not taken");
        // R10 other conditions
        drive(mk(7'h00, 3'd1, 7'h63), 32'h2000, 9, 8, 32'hFFFF_FFF0, 0, 0, 32'h11, 1, 32'h1FF0, "R10 R11 bne back");
        drive(mk(7'h00, 3'd4, 7'h63), 32'h40, 32'hFFFF_FFFF, 1, 8, 0, 0, 0, 1, 32'h48, "R10 blt");
        drive(mk(7'h00, 3'd6, 7'h63), 32'h40, 32'hFFFF_FFFF, 1, 8, 0, 0, 0, 0, 0, "R10 bltu");
        drive(mk(7'h00, 3'd5, 7'h63), 32'h40, 1, 32'hFFFF_FFFF, 8, 0, 0, 0, 1, 32'h48, "R10 bge");
        drive(mk(7'h00, 3'd7, 7'h63), 32'h40, 1, 32'hFFFF_FFFF, 8, 0, 0, 0, 0, 0, "R10 bgeu");
        drive(mk(7'h00, 3'd2, 7'h63), 32'h40, 3, 3, 8, 0, 0, 32'd6, 0, 0, "R10 reserved cond");
        // R12 jal
        drive(mk(7'h00, 3'd0, 7'h6F), 32'h1000, 0, 0, 32'h20, 0, 0, 0, 1, 32'h1020, "R12 jal");
        // R13 jalr
        drive(mk(7'h00, 3'd0, 7'h67), 0, 32'h3001, 0, 4, 0, 1, 32'h3005, 1, 32'h3004, "R13 jalr");
        drive(mk(7'h00, 3'd0, 7'h67), 0, 32'h100, 0, 32'hFFFF_FFFF, 0, 1, 32'hFF, 1, 32'hFE, "R13 jalr neg");
        while (queue_exp.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule